// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter Channel

This block is one counting channel for a rotary or linear encoder. Three raw inputs enter it: the two phase signals A and B and the index mark Z. Each passes through a synchroniser to the system clock. The synchronised phases are then decoded, according to the selected input mode, into single up or down steps. These steps drive a 24-bit wrapping counter. The modes are quadrature (one, two or four counts per encoder cycle), pulse with direction level, separate up and down pulse lines, and off.

Two channels can be chained into one 48-bit counter. The high-order channel has its cascade enable set. It then ignores its own phase inputs and steps only when the low-order channel wraps. The wrap strobes are combinational, so both halves change on the same clock edge. A synchronous clear loads either zero or midscale. An index-seen flag catches rising edges of Z until software-side logic acknowledges it. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `quad_count_chan`

## Requirements
- R1: In quadrature mode with `mult`=2 or 3 (4x), every single-phase transition counts one. Direction is up when A leads B (sequence AB 00,10,11,01) and down when B leads A. A sample where A and B both change produces no count.
- R2: In quadrature mode with `mult`=1 (2x), only edges of A count. With `mult`=0 (1x), only rising edges of A count. The direction follows the same rule as R1.
- R3: In pulse/direction mode (`mode`=2), each rising edge of A counts one: up when B is high, down when B is low. Edges of B alone do not count.
- R4: In up/down pulse mode (`mode`=3), a rising edge of A counts up and a rising edge of B counts down. Rising edges of both in the same sample cancel.
- R5: In the off mode (`mode`=0), the count holds whatever A and B do. Only `cnt_clr` changes it.
- R6: `cnt_clr` loads 0x000000 when `mid_sel` is low and 0x800000 when it is high, on the next clock edge. It takes priority over counting.
- R7: The count wraps from 0xFFFFFF to 0 when counting up and from 0 to 0xFFFFFF when counting down. `ovf` is high for exactly the one cycle after each wrap.
- R8: With `casc_en` high, the channel ignores A and B. It counts up on `cy_up_in` and down on `cy_dn_in`. `cy_up_out` and `cy_dn_out` are high in the same cycle as the step that wraps the count, so a chained pair forms one 48-bit counter.
- R9: `idx_seen` sets on a synchronised rising edge of Z and stays set until `idx_ack` is pulsed. It then reads 0.
- R10: After `rst_n` is low, the count is 0 and `ovf`, `idx_seen` and both wrap strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw phase A |
| enc_b | input | 1 | Raw phase B |
| enc_z | input | 1 | Raw index mark |
| mode | input | 2 | 0 off, 1 quadrature, 2 pulse/direction, 3 up/down pulses |
| mult | input | 2 | Quadrature rate: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| mid_sel | input | 1 | Clear value: 0 = zero, 1 = midscale |
| cnt_clr | input | 1 | Synchronous load of the clear value |
| casc_en | input | 1 | Count from the neighbour's wrap strobes instead of A/B |
| cy_up_in | input | 1 | Up-wrap strobe from the low-order channel |
| cy_dn_in | input | 1 | Down-wrap strobe from the low-order channel |
| idx_ack | input | 1 | Clears the index-seen flag |
| count | output | 24 | Live count |
| ovf | output | 1 | One-cycle pulse after a wrap |
| idx_seen | output | 1 | Index rising edge seen |
| cy_up_out | output | 1 | Current step wraps upward |
| cy_dn_out | output | 1 | Current step wraps downward |

## Verification
The phase pair is driven through full forward and reverse quadrature cycles, and through an illegal double change. At 4x this separates the direction rule from a mere edge count. The 2x and 1x runs then reuse the same waveforms, which shows that B edges, and at 1x also falling A edges, are dropped while direction is still decided correctly. Pulse/direction and up/down pulse runs show that only A rising edges or the chosen line count, and that simultaneous pulses cancel. A chained pair is stepped across 0 in both directions to show that the 48-bit value moves as one word with a single overflow pulse.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  typedef enum logic [1:0] {
    QM_OFF  = 2'd0,
    QM_QUAD = 2'd1,
    QM_PDIR = 2'd2,
    QM_UPDN = 2'd3
  } qmode_e;

  typedef enum logic [1:0] {
    QX_1  = 2'd0,
    QX_2  = 2'd1,
    QX_4  = 2'd2,
    QX_4B = 2'd3
  } qmult_e;

  typedef struct packed {
    logic up;
    logic dn;
  } qstep_t;
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[i] <= '0;
      else        pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
  import qcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   a,
  input  logic   b,
  input  qmode_e mode,
  input  qmult_e mult,
  output qstep_t step
);
  logic a_p, b_p;
  logic da, db, single, fwd, rise_a, rise_b, quad_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
    end else begin
      a_p <= a;
      b_p <= b;
    end
  end

  assign da     = a ^ a_p;
  assign db     = b ^ b_p;
  assign single = da ^ db;
  assign fwd    = a ^ b_p;
  assign rise_a = da & a;
  assign rise_b = db & b;

  always_comb begin
    unique case (mult)
      QX_1:    quad_cnt = rise_a & ~db;
      QX_2:    quad_cnt = da & ~db;
      default: quad_cnt = single;
    endcase
  end

  always_comb begin
    step = '{up: 1'b0, dn: 1'b0};
    unique case (mode)
      QM_QUAD: begin
        step.up = quad_cnt & fwd;
        step.dn = quad_cnt & ~fwd;
      end
      QM_PDIR: begin
        step.up = rise_a & b;
        step.dn = rise_a & ~b;
      end
      QM_UPDN: begin
        step.up = rise_a & ~rise_b;
        step.dn = rise_b & ~rise_a;
      end
      default: step = '{up: 1'b0, dn: 1'b0};
    endcase
  end
endmodule

// File: rtl/qcnt_index.sv
module qcnt_index (
  input  logic clk,
  input  logic rst_n,
  input  logic z,
  input  logic ack,
  output logic seen
);
  logic z_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_p  <= 1'b0;
      seen <= 1'b0;
    end else begin
      z_p <= z;
      if (z & ~z_p)  seen <= 1'b1;
      else if (ack)  seen <= 1'b0;
    end
  end
endmodule

// File: rtl/qcnt_counter.sv
module qcnt_counter
  import qcnt_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  qstep_t       step,
  input  logic         clr,
  input  logic [W-1:0] clr_val,
  output logic [W-1:0] count,
  output logic         ovf,
  output logic         wrap_up,
  output logic         wrap_dn
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign wrap_up = ~clr & step.up & (count == TOP);
  assign wrap_dn = ~clr & ~step.up & step.dn & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= clr_val;
      ovf   <= 1'b0;
    end else begin
      ovf <= wrap_up | wrap_dn;
      if (step.up)      count <= count + 1'b1;
      else if (step.dn) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/quad_count_chan.sv
module quad_count_chan
  import qcnt_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic [1:0]       mode,
  input  logic [1:0]       mult,
  input  logic             mid_sel,
  input  logic             cnt_clr,
  input  logic             casc_en,
  input  logic             cy_up_in,
  input  logic             cy_dn_in,
  input  logic             idx_ack,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             idx_seen,
  output logic             cy_up_out,
  output logic             cy_dn_out
);
  localparam logic [CNT_W-1:0] MID_VAL = CNT_W'(1) << (CNT_W - 1);

  logic [2:0]       raw, syn;
  qstep_t           dec_step, sel_step;
  qmode_e           mode_e;
  logic [CNT_W-1:0] clr_val;

  assign raw    = {enc_z, enc_b, enc_a};
  assign mode_e = qmode_e'(mode);

  qcnt_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  qcnt_decode u_dec (
    .clk(clk), .rst_n(rst_n), .a(syn[0]), .b(syn[1]),
    .mode(mode_e), .mult(qmult_e'(mult)), .step(dec_step)
  );

  qcnt_index u_idx (
    .clk(clk), .rst_n(rst_n), .z(syn[2]), .ack(idx_ack), .seen(idx_seen)
  );

  always_comb begin
    if (mode_e == QM_OFF) sel_step = '{up: 1'b0, dn: 1'b0};
    else if (casc_en)     sel_step = '{up: cy_up_in, dn: cy_dn_in & ~cy_up_in};
    else                  sel_step = dec_step;
  end

  assign clr_val = mid_sel ? MID_VAL : '0;

  qcnt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(sel_step), .clr(cnt_clr),
    .clr_val(clr_val), .count(count), .ovf(ovf),
    .wrap_up(cy_up_out), .wrap_dn(cy_dn_out)
  );
endmodule

// File: rtl/qcnt_chk.sv
module qcnt_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             mid_sel,
  input logic             cnt_clr,
  input logic             idx_ack,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             idx_seen,
  input logic             cy_up_out,
  input logic             cy_dn_out
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !cnt_clr) |=> count == $past(count)); // R5

  AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> count == ($past(mid_sel) ? MID : '0)); // R6

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (count == $past(count) || count == $past(count) + ONE
                  || count == $past(count) - ONE)); // R1

  AST_OVF_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0 || count == TOP)); // R7

  AST_WRAP_UP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cy_up_out |=> (count == '0 && ovf)); // R8

  AST_WRAP_DN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cy_dn_out |=> (count == TOP && ovf)); // R8

  AST_IDX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_seen && !idx_ack) |=> idx_seen); // R9
endmodule

bind quad_count_chan qcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mid_sel(mid_sel),
  .cnt_clr(cnt_clr), .idx_ack(idx_ack), .count(count), .ovf(ovf),
  .idx_seen(idx_seen), .cy_up_out(cy_up_out), .cy_dn_out(cy_dn_out)
);

// File: tb/tb_quad_count_chan.sv
`timescale 1ns/1ps
module tb_quad_count_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 0, b = 0, z = 0;
  logic [1:0] mode = 2'd1, mult = 2'd2;
  logic mid_sel = 0, clr = 0, ack = 0;
  logic [23:0] cnt_lo, cnt_hi;
  logic ovf_lo, ovf_hi, idx_lo, idx_hi;
  logic up_lo, dn_lo, up_hi, dn_hi;
  int n_tests = 0, n_fail = 0, ovf_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_count_chan dut (
    .clk(clk), .rst_n(rst_n), .enc_a(a), .enc_b(b), .enc_z(z),
    .mode(mode), .mult(mult), .mid_sel(mid_sel), .cnt_clr(clr),
    .casc_en(1'b0), .cy_up_in(1'b0), .cy_dn_in(1'b0), .idx_ack(ack),
    .count(cnt_lo), .ovf(ovf_lo), .idx_seen(idx_lo),
    .cy_up_out(up_lo), .cy_dn_out(dn_lo)
  );

  quad_count_chan dut_hi (
    .clk(clk), .rst_n(rst_n), .enc_a(a), .enc_b(b), .enc_z(1'b0),
    .mode(mode), .mult(mult), .mid_sel(mid_sel), .cnt_clr(clr),
    .casc_en(1'b1), .cy_up_in(up_lo), .cy_dn_in(dn_lo), .idx_ack(1'b0),
    .count(cnt_hi), .ovf(ovf_hi), .idx_seen(idx_hi),
    .cy_up_out(up_hi), .cy_dn_out(dn_hi)
  );

  always @(negedge clk) if (ovf_lo) ovf_seen++;

  // {mode, mult, a, b, expected count}
  localparam int NV = 35;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1,2'd2,1'b1,1'b0,24'd1}, {2'd1,2'd2,1'b1,1'b1,24'd2},   // R1 forward
    {2'd1,2'd2,1'b0,1'b1,24'd3}, {2'd1,2'd2,1'b0,1'b0,24'd4},
    {2'd1,2'd2,1'b0,1'b1,24'd3}, {2'd1,2'd2,1'b1,1'b1,24'd2},   // R1 reverse
    {2'd1,2'd2,1'b0,1'b0,24'd2},                                 // R1 illegal
    {2'd1,2'd1,1'b1,1'b0,24'd3}, {2'd1,2'd1,1'b1,1'b1,24'd3},   // R2 2x
    {2'd1,2'd1,1'b0,1'b1,24'd4}, {2'd1,2'd1,1'b0,1'b0,24'd4},
    {2'd1,2'd0,1'b1,1'b0,24'd5}, {2'd1,2'd0,1'b1,1'b1,24'd5},   // R2 1x
    {2'd1,2'd0,1'b0,1'b1,24'd5}, {2'd1,2'd0,1'b0,1'b0,24'd5},
    {2'd1,2'd0,1'b0,1'b1,24'd5}, {2'd1,2'd0,1'b1,1'b1,24'd4},
    {2'd1,2'd0,1'b1,1'b0,24'd4}, {2'd1,2'd0,1'b0,1'b0,24'd4},
    {2'd2,2'd0,1'b0,1'b1,24'd4}, {2'd2,2'd0,1'b1,1'b1,24'd5},   // R3
    {2'd2,2'd0,1'b0,1'b1,24'd5}, {2'd2,2'd0,1'b1,1'b1,24'd6},
    {2'd2,2'd0,1'b1,1'b0,24'd6}, {2'd2,2'd0,1'b0,1'b0,24'd6},
    {2'd2,2'd0,1'b1,1'b0,24'd5}, {2'd2,2'd0,1'b0,1'b0,24'd5},
    {2'd3,2'd0,1'b1,1'b0,24'd6}, {2'd3,2'd0,1'b0,1'b0,24'd6},   // R4
    {2'd3,2'd0,1'b0,1'b1,24'd5}, {2'd3,2'd0,1'b0,1'b0,24'd5},
    {2'd3,2'd0,1'b1,1'b1,24'd5}, {2'd3,2'd0,1'b0,1'b0,24'd5},
    {2'd0,2'd0,1'b1,1'b0,24'd5}, {2'd0,2'd0,1'b0,1'b0,24'd5}    // R5
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_to(input logic mid);
    @(negedge clk);
    mid_sel = mid; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 count", {24'd0, cnt_lo}, 48'd0);
    chk("R10 ovf", {47'd0, ovf_lo}, 48'd0);
    chk("R10 idx", {47'd0, idx_lo}, 48'd0);
    chk("R10 wrap", {46'd0, up_lo, dn_lo}, 48'd0);
    rst_n = 1'b1;
    settle();

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][29:28];
      mult = VEC[i][27:26];
      a    = VEC[i][25];
      b    = VEC[i][24];
      settle();
      chk($sformatf("R1-R5 vector %0d", i), {24'd0, cnt_lo}, {24'd0, VEC[i][23:0]});
    end

    // R6 midscale clear, even in the off mode
    clear_to(1'b1);
    chk("R6 mid", {24'd0, cnt_lo}, 48'h800000);
    clear_to(1'b0);
    chk("R6 zero", {24'd0, cnt_lo}, 48'd0);

    // R7 / R8 chained wrap downward then upward
    mode = 2'd1; mult = 2'd2;
    ovf_seen = 0;
    b = 1'b1; settle();
    chk("R8 48-bit down", {cnt_hi, cnt_lo}, 48'hFFFF_FFFF_FFFF);
    chk("R7 ovf down once", 48'(ovf_seen), 48'd1);
    ovf_seen = 0;
    b = 1'b0; settle();
    chk("R8 48-bit up", {cnt_hi, cnt_lo}, 48'd0);
    chk("R7 ovf up once", 48'(ovf_seen), 48'd1);
    a = 1'b1; settle();
    chk("R8 high ignores phases", {cnt_hi, cnt_lo}, 48'd1);

    // R9 index flag
    z = 1'b1; settle();
    chk("R9 set", {47'd0, idx_lo}, 48'd1);
    z = 1'b0; settle();
    chk("R9 sticky", {47'd0, idx_lo}, 48'd1);
    ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
    chk("R9 ack", {47'd0, idx_lo}, 48'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule